// File: doc/BRIEF.md
# Double-Buffered Channel Profile Loader

The block takes channel impulse-response profiles from a 32-bit host stream and keeps them in two coefficient banks for a bank of FIR filters. Host words pass through a small FIFO. An unpacking stage splits each word into two 16-bit coefficients, and a sequencer writes those coefficients one per cycle into the bank that the filters are not reading. A full profile has one coefficient for every tap of every channel. With the default sizes that is 4 channels of 18 taps, or 72 words.

The filters read the active bank through a combinational port indexed by channel and tap. When the profile in the inactive bank is complete, the block raises a done flag and stops taking more host data. A refresh tick then swaps the two banks. A tick that comes before the profile is complete does not swap the banks. Instead it raises a sticky underrun flag, and the partial load carries on.

Top module: `chan_profile_loader`

## Requirements
- R1: After reset, bank 0 is active, `load_done_o` and `underrun_o` are low, `host_ready_o` is high, and every coefficient in both banks reads 0.
- R2: `host_ready_o` is high exactly when the FIFO holds fewer than FIFO_DEPTH words. A word offered while it is low is dropped and never appears in any bank.
- R3: From each accepted host word, bits 15:0 become a coefficient first and bits 31:16 become the next one.
- R4: Within a profile, the k-th coefficient (counting from 0) goes to channel k / NUM_TAPS, tap k % NUM_TAPS. It is read back with `rd_ch_i` = channel and `rd_tap_i` = tap.
- R5: `load_done_o` rises in the cycle after the last coefficient of a profile is written. It stays high until a swap. While it is high, no further coefficient is taken, so host words wait in the FIFO.
- R6: A refresh tick while `load_done_o` is high toggles `active_bank_o` on the next cycle. The same swap clears `load_done_o` and `underrun_o`, and the newly active bank reads back the profile just loaded.
- R7: A refresh tick while `load_done_o` is low keeps `active_bank_o` unchanged and sets `underrun_o`. Loading continues where it was.
- R8: Writes go only to the inactive bank. Without a swap, the value read for a given channel and tap does not change.
- R9: A refresh tick in the same cycle as the final coefficient write counts as early. The result is an underrun with no swap, and `load_done_o` rises on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_valid_i | input | 1 | Host word offered |
| host_data_i | input | 32 | Host word holding two coefficients |
| host_ready_o | output | 1 | FIFO has room |
| refresh_i | input | 1 | Refresh tick requesting a bank swap |
| rd_ch_i | input | 2 | Channel select for the read port |
| rd_tap_i | input | 5 | Tap select for the read port |
| rd_coef_o | output | 16 | Coefficient from the active bank |
| load_done_o | output | 1 | Inactive bank holds a complete profile |
| underrun_o | output | 1 | A tick arrived before the profile was complete |
| active_bank_o | output | 1 | Index of the bank being read |

## Verification
The final coefficient write and a refresh tick can land in the same cycle. The rule is that the tick is early: it gives an underrun, no swap happens, and done follows one cycle later. The bench provokes this by watching its own behavioural model. It raises the tick on the exact cycle in which the model expects the last word of a profile to be written. It then checks that the bank index is unchanged, that underrun is set and that done is set. A second overlap is also exercised: a swap arriving while the FIFO is full and the host keeps offering words. Here the dropped words must never show up in the next profile.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/lp_fifo.sv
module lp_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [WIDTH-1:0] store_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = store_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) store_q[wr_ptr_q] <= push_data_i;
  end
endmodule

// File: rtl/lp_unpack.sv
module lp_unpack import lp_pkg::*; #(
  parameter int unsigned COEF_W = 16,
  localparam int unsigned HOST_W = 2 * COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic [HOST_W-1:0] fifo_data_i,
  output logic              fifo_pop_o,
  input  logic              take_i,
  output logic              word_vld_o,
  output logic [COEF_W-1:0] word_o
);
  logic [HOST_W-1:0] hold_q;
  logic              hold_vld_q;
  half_e             half_q;

  assign word_vld_o = hold_vld_q;
  assign word_o     = (half_q == HALF_HI) ? hold_q[HOST_W-1:COEF_W] : hold_q[COEF_W-1:0];
  // refill when empty, or when the upper half is being consumed now
  assign fifo_pop_o = !fifo_empty_i && (!hold_vld_q || (take_i && half_q == HALF_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      half_q     <= HALF_LO;
    end else if (fifo_pop_o) begin
      hold_q     <= fifo_data_i;
      hold_vld_q <= 1'b1;
      half_q     <= HALF_LO;
    end else if (take_i && hold_vld_q) begin
      if (half_q == HALF_LO) begin
        half_q <= HALF_HI;
      end else begin
        hold_vld_q <= 1'b0;
        half_q     <= HALF_LO;
      end
    end
  end
endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl #(
  parameter int unsigned NUM_WORDS = 72,
  localparam int unsigned IDX_W = $clog2(NUM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_vld_i,
  input  logic             refresh_i,
  output logic             take_o,
  output logic             wr_bank_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             bank_o,
  output logic             done_o,
  output logic             underrun_o
);
  logic [IDX_W-1:0] widx_q;
  logic             bank_q, done_q, und_q;
  logic             last_wr, swap;

  assign take_o    = word_vld_i && !done_q;
  assign last_wr   = take_o && (widx_q == IDX_W'(NUM_WORDS - 1));
  assign swap      = refresh_i && done_q;
  assign wr_bank_o = ~bank_q;
  assign wr_idx_o  = widx_q;
  assign bank_o    = bank_q;
  assign done_o    = done_q;
  assign underrun_o = und_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q <= '0;
      bank_q <= 1'b0;
      done_q <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      if (take_o) widx_q <= last_wr ? '0 : widx_q + IDX_W'(1);
      if (swap) begin
        bank_q <= ~bank_q;
        done_q <= 1'b0;
        und_q  <= 1'b0;
      end else begin
        if (last_wr)   done_q <= 1'b1;
        if (refresh_i) und_q  <= 1'b1;  // done_q low here: early tick
      end
    end
  end
endmodule

// File: rtl/lp_bank_store.sv
module lp_bank_store import lp_pkg::*; #(
  parameter int unsigned COEF_W    = 16,
  parameter int unsigned NUM_WORDS = 72,
  localparam int unsigned IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [COEF_W-1:0] wr_data_i,
  input  logic              rd_bank_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [COEF_W-1:0] rd_data_o
);
  logic [COEF_W-1:0] rd_word [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [COEF_W-1:0] mem_q [NUM_WORDS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
      end else if (wr_en_i && wr_bank_i == 1'(b)) begin
        mem_q[wr_idx_i] <= wr_data_i;
      end
    end

    assign rd_word[b] = mem_q[rd_idx_i];
  end

  assign rd_data_o = rd_en_i ? rd_word[rd_bank_i] : '0;
endmodule

// File: rtl/chan_profile_loader.sv
module chan_profile_loader import lp_pkg::*; #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned NUM_TAPS   = 18,
  parameter int unsigned COEF_W     = 16,
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned HOST_W = 2 * COEF_W,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned TAP_W  = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_valid_i,
  input  logic [HOST_W-1:0] host_data_i,
  output logic              host_ready_o,
  input  logic              refresh_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  input  logic [TAP_W-1:0]  rd_tap_i,
  output logic [COEF_W-1:0] rd_coef_o,
  output logic              load_done_o,
  output logic              underrun_o,
  output logic              active_bank_o
);
  localparam int unsigned NUM_WORDS = NUM_CH * NUM_TAPS;
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);

  logic              fifo_full, fifo_empty, fifo_pop;
  logic [HOST_W-1:0] fifo_head;
  logic              word_vld, take;
  logic [COEF_W-1:0] word;
  logic              wr_bank, bank;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              rd_ok;

  assign host_ready_o = !fifo_full;

  lp_fifo #(.WIDTH(HOST_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (host_valid_i),
    .push_data_i (host_data_i),
    .pop_i       (fifo_pop),
    .head_o      (fifo_head),
    .empty_o     (fifo_empty),
    .full_o      (fifo_full)
  );

  lp_unpack #(.COEF_W(COEF_W)) u_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_head),
    .fifo_pop_o   (fifo_pop),
    .take_i       (take),
    .word_vld_o   (word_vld),
    .word_o       (word)
  );

  lp_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_vld_i (word_vld),
    .refresh_i  (refresh_i),
    .take_o     (take),
    .wr_bank_o  (wr_bank),
    .wr_idx_o   (wr_idx),
    .bank_o     (bank),
    .done_o     (load_done_o),
    .underrun_o (underrun_o)
  );

  // channel-major linear index, out-of-range selects read zero
  assign rd_ok  = ({1'b0, rd_tap_i} < (TAP_W + 1)'(NUM_TAPS)) &&
                  ({1'b0, rd_ch_i} < (CH_W + 1)'(NUM_CH));
  assign rd_idx = IDX_W'(rd_ch_i) * IDX_W'(NUM_TAPS) + IDX_W'(rd_tap_i);

  lp_bank_store #(.COEF_W(COEF_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (take),
    .wr_bank_i (wr_bank),
    .wr_idx_i  (wr_idx),
    .wr_data_i (word),
    .rd_bank_i (bank),
    .rd_en_i   (rd_ok),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_coef_o)
  );

  assign active_bank_o = bank;
endmodule

// File: rtl/lp_chk.sv
module lp_chk #(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned TAP_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_ready_o,
  input logic              refresh_i,
  input logic [CH_W-1:0]   rd_ch_i,
  input logic [TAP_W-1:0]  rd_tap_i,
  input logic [COEF_W-1:0] rd_coef_o,
  input logic              load_done_o,
  input logic              underrun_o,
  input logic              active_bank_o
);
  // R6
  swap_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i && load_done_o |=> (active_bank_o != $past(active_bank_o)) && !load_done_o && !underrun_o);

  // R7
  early_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i && !load_done_o |=> $stable(active_bank_o) && underrun_o);

  // R6
  bank_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh_i |=> $stable(active_bank_o));

  // R5
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o && !refresh_i |=> load_done_o);

  // R5
  stall_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o && !refresh_i && !host_ready_o |=> !host_ready_o);

  // R8
  read_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh_i |=> (!$stable(rd_ch_i) || !$stable(rd_tap_i) || $stable(rd_coef_o)));
endmodule

bind chan_profile_loader lp_chk #(.COEF_W(COEF_W), .CH_W(CH_W), .TAP_W(TAP_W)) u_chk (.*);

// File: tb/chan_profile_loader_tb.sv
`timescale 1ns/1ps
module chan_profile_loader_tb_top;
  localparam int DEPTH = 8;
  localparam int NT    = 18;
  localparam int NW    = 72;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_r = 1'b0;
  logic [31:0] data_r = '0;
  logic        refresh_r = 1'b0;
  logic [1:0]  rd_ch_r = '0;
  logic [4:0]  rd_tap_r = '0;
  logic        host_ready_o, load_done_o, underrun_o, active_bank_o;
  logic [15:0] rd_coef_o;

  always #2 clk_i = ~clk_i;

  chan_profile_loader dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_valid_i (valid_r),
    .host_data_i  (data_r),
    .host_ready_o (host_ready_o),
    .refresh_i    (refresh_r),
    .rd_ch_i      (rd_ch_r),
    .rd_tap_i     (rd_tap_r),
    .rd_coef_o    (rd_coef_o),
    .load_done_o  (load_done_o),
    .underrun_o   (underrun_o),
    .active_bank_o(active_bank_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, rd_k = 0;
  logic [15:0] lfsr = 16'hace1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] coef(input int p, input int k);
    int v;
    v = p * 977 + k * 131 + 4660 + (k % 7) * 4096;
    return v[15:0];
  endfunction

  function automatic logic [31:0] host_word(input int p, input int j);
    return {coef(p, 2 * j + 1), coef(p, 2 * j)};
  endfunction

  // behavioural reference model
  logic [31:0] m_fifo [$];
  logic [31:0] m_hold;
  bit          m_hold_vld, m_half, m_done, m_und, m_bank;
  int          m_widx;
  logic [15:0] m_mem [2][NW];
  bit          acc, pop, d0;
  int          sz;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_fifo.delete();
      m_hold = '0; m_hold_vld = 0; m_half = 0;
      m_done = 0; m_und = 0; m_bank = 0; m_widx = 0;
      for (int b = 0; b < 2; b++) for (int i = 0; i < NW; i++) m_mem[b][i] = '0;
    end else begin
      sz  = m_fifo.size();
      d0  = m_done;
      acc = m_hold_vld && !m_done;
      pop = (sz > 0) && (!m_hold_vld || (acc && m_half));
      if (acc) begin
        m_mem[!m_bank][m_widx] = m_half ? m_hold[31:16] : m_hold[15:0];
        if (m_widx == NW - 1) begin m_widx = 0; m_done = 1; end
        else m_widx++;
      end
      if (pop) begin
        m_hold = m_fifo.pop_front(); m_hold_vld = 1; m_half = 0;
      end else if (acc) begin
        if (m_half) begin m_hold_vld = 0; m_half = 0; end
        else m_half = 1;
      end
      if (valid_r && sz < DEPTH) m_fifo.push_back(data_r);
      if (refresh_r && d0) begin m_bank = !m_bank; m_done = 0; m_und = 0; end
      else if (refresh_r) m_und = 1;
    end
  end

  // per-cycle comparison, then advance the read sweep
  always @(posedge clk_i) begin
    #1;
    cyc++;
    if (rst_ni) begin
      check(host_ready_o === (m_fifo.size() < DEPTH), "R2 ready", 32'(host_ready_o), 32'(m_fifo.size() < DEPTH));
      check(load_done_o === m_done, "R5 done", 32'(load_done_o), 32'(m_done));
      check(underrun_o === m_und, "R7 underrun", 32'(underrun_o), 32'(m_und));
      check(active_bank_o === m_bank, "R6 bank", 32'(active_bank_o), 32'(m_bank));
      check(rd_coef_o === m_mem[m_bank][rd_k], "R4 coef", 32'(rd_coef_o), 32'(m_mem[m_bank][rd_k]));
    end
    rd_k     = (rd_k + 1) % NW;
    rd_ch_r  = 2'(rd_k / NT);
    rd_tap_r = 5'(rd_k % NT);
  end

  task automatic check_active(input int p);
    @(negedge clk_i);
    check(rd_coef_o === coef(p, rd_k), "R3 read of loaded profile", 32'(rd_coef_o), 32'(coef(p, rd_k)));
  endtask

  task automatic pulse_refresh();
    @(negedge clk_i) refresh_r = 1'b1;
    @(negedge clk_i) refresh_r = 1'b0;
  endtask

  task automatic send_profile(input int p, input bit gaps, input int refresh_at, input bit junk);
    int j = 0;
    int cnt = 0;
    while (j < 36) begin
      @(negedge clk_i);
      if (refresh_at >= 0) refresh_r = (cnt == refresh_at);
      cnt++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (gaps && lfsr[1:0] == 2'b00) begin
        valid_r = 1'b0;
      end else if (host_ready_o) begin
        valid_r = 1'b1; data_r = host_word(p, j); j++;
      end else begin
        valid_r = junk; data_r = 32'hdead_beef;
      end
    end
    @(negedge clk_i);
    valid_r = 1'b0;
    if (refresh_at >= 0) refresh_r = 1'b0;
  endtask

  task automatic wait_done();
    while (!load_done_o) @(negedge clk_i);
  endtask

  task automatic refresh_on_last();
    bit prev;
    bit hit = 0;
    while (!hit) begin
      @(negedge clk_i);
      if (m_hold_vld && !m_done && m_widx == NW - 1 && m_half) begin
        prev = active_bank_o;
        refresh_r = 1'b1;
        @(negedge clk_i);
        refresh_r = 1'b0;
        check(underrun_o === 1'b1, "R9 underrun on coincident tick", 32'(underrun_o), 32'd1);
        check(load_done_o === 1'b1, "R9 done after coincident tick", 32'(load_done_o), 32'd1);
        check(active_bank_o === prev, "R9 bank kept", 32'(active_bank_o), 32'(prev));
        hit = 1;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(host_ready_o === 1'b1, "R1 ready", 32'(host_ready_o), 32'd1);
    check(load_done_o === 1'b0, "R1 done", 32'(load_done_o), 32'd0);
    check(underrun_o === 1'b0, "R1 underrun", 32'(underrun_o), 32'd0);
    check(active_bank_o === 1'b0, "R1 bank", 32'(active_bank_o), 32'd0);
    check(rd_coef_o === 16'h0, "R1 coef", 32'(rd_coef_o), 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    pulse_refresh();
    check(underrun_o === 1'b1, "R7 early tick underrun", 32'(underrun_o), 32'd1);
    check(active_bank_o === 1'b0, "R7 early tick bank", 32'(active_bank_o), 32'd0);

    send_profile(1, 1'b0, -5, 1'b0);
    wait_done();
    check(load_done_o === 1'b1, "R5 done after full profile", 32'(load_done_o), 32'd1);

    fork
      begin
        send_profile(2, 1'b0, -5, 1'b1);
        refresh_on_last();
      end
      begin
        repeat (30) @(negedge clk_i);
        check(host_ready_o === 1'b0, "R5 FIFO fills while done", 32'(host_ready_o), 32'd0);
        pulse_refresh();
        check(active_bank_o === 1'b1, "R6 swapped bank", 32'(active_bank_o), 32'd1);
        check(underrun_o === 1'b0, "R6 underrun cleared", 32'(underrun_o), 32'd0);
        for (int i = 0; i < NW; i++) check_active(1);
      end
    join

    pulse_refresh();
    check(active_bank_o === 1'b0, "R6 second swap", 32'(active_bank_o), 32'd0);
    for (int i = 0; i < NW; i++) check_active(2);

    send_profile(3, 1'b1, 10, 1'b0);
    check(underrun_o === 1'b1, "R7 mid-load tick", 32'(underrun_o), 32'd1);
    wait_done();
    pulse_refresh();
    for (int i = 0; i < NW; i++) check_active(3);

    repeat (4) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule